// File: doc/BRIEF.md
# Two-Dimensional Broadcast Address Filter

This block sits in one row of a processing-element array. A memory controller drives a stream of (address, data) beats, and the same stream reaches every row at once. Each row keeps only the beats whose address falls inside its own programmed two-dimensional region. No row ever issues a request of its own, and no cache hierarchy is involved. Because selection is local, strided walks over a tensor and circular (wrap-around) indexing for circular convolution both cost one broadcast pass and nothing more.

The address is split into a row coordinate (upper bits) and a column coordinate (lower bits). Each coordinate goes through its own window test: an inclusive bound pair and a step size, plus an optional wrap mode that reduces the column by a vector length and lets a window straddle the wrap point. Settings are held constant for the whole of a pass. The beats that are kept go into a small first-in first-out queue that feeds the row's PEs. When the queue is full, the filter stalls the broadcast rather than dropping data. A counter reports how many beats the current pass has captured.

Top module: `bcast_window_filter`

## Requirements
- R1: The row coordinate is `bc_addr[ROW_W+COL_W-1:COL_W]`. With `cfg_row_lo <= cfg_row_hi`, a beat passes the row test only when `cfg_row_lo <= row <= cfg_row_hi`, with both bounds inclusive.
- R2: The column coordinate is `bc_addr[COL_W-1:0]`. With `cfg_col_lo <= cfg_col_hi`, it passes the column test only when it lies inside the inclusive bound pair. A beat is captured only when both tests pass.
- R3: A step value of 0 or 1 accepts every coordinate in the window. A larger step accepts a coordinate only when its distance above the low bound, counted modulo the dimension's span, is a whole multiple of the step.
- R4: When `cfg_mod_en` is 1 and a window's low bound exceeds its high bound, that window selects coordinates `>= lo` or `<= hi`. When `cfg_mod_en` is 0, such a window selects nothing.
- R5: When `cfg_mod_en` is 1 and `cfg_vec_len` is non-zero, the column coordinate is first reduced modulo `cfg_vec_len`. That value is also the column span used for step alignment. When `cfg_vec_len` is 0, or `cfg_mod_en` is 0, the column is used as it is with a span of 2^COL_W.
- R6: Captured beats appear on `pe_valid`/`pe_addr`/`pe_data` in arrival order, starting one cycle after the beat is accepted. A beat leaves the queue on a cycle where `pe_valid` and `pe_ready` are both 1.
- R7: The queue holds `FIFO_DEPTH` beats. While it is full, `bc_ready` is 0, no beat is accepted, and no stored beat is lost or altered.
- R8: `match_count` goes up by one for each captured beat. A `pass_start` pulse clears it. A beat captured in the same cycle as `pass_start` counts as the first capture of the new pass, so the count becomes 1.
- R9: After reset, `pe_valid` is 0, `bc_ready` is 1 and `match_count` is 0.
- R10: A beat that is accepted but fails either test leaves the outputs and `match_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pass_start | input | 1 | Start-of-pass pulse that clears the capture counter |
| cfg_mod_en | input | 1 | Enables wrapped windows and column modulo reduction |
| cfg_row_lo | input | ROW_W | Row window low bound |
| cfg_row_hi | input | ROW_W | Row window high bound |
| cfg_row_stride | input | ROW_W | Row step size |
| cfg_col_lo | input | COL_W | Column window low bound |
| cfg_col_hi | input | COL_W | Column window high bound |
| cfg_col_stride | input | COL_W | Column step size |
| cfg_vec_len | input | COL_W+1 | Column modulus (0 means no reduction) |
| bc_valid | input | 1 | Broadcast beat present |
| bc_addr | input | ROW_W+COL_W | Broadcast beat address |
| bc_data | input | DATA_W | Broadcast beat payload |
| bc_ready | output | 1 | Row can accept a beat |
| pe_valid | output | 1 | Captured beat available to the PEs |
| pe_addr | output | ROW_W+COL_W | Address of the head captured beat |
| pe_data | output | DATA_W | Payload of the head captured beat |
| pe_ready | input | 1 | PEs take the head beat |
| match_count | output | CNT_W | Beats captured in the current pass |

## Verification
The bench builds the filter with 4-bit row and column coordinates, 8-bit data and a 4-entry queue. With these widths the coordinate extremes 0 and 15, the wrap of a straddling window, and a vector length of 10 that does not divide the column range can all be reached with a few hand-checked addresses. A depth of 4 lets the queue be filled, held against a waiting beat, and drained in order within a dozen cycles. The step-alignment variant is enabled, so strided selection across a wrapped window is exercised as well.

// File: rtl/bwf_pkg.sv
`timescale 1ns/1ps
package bwf_pkg;
   // Shape of one coordinate window: ordinary, or straddling the wrap point.
   typedef enum logic {
      WIN_LINEAR  = 1'b0,
      WIN_WRAPPED = 1'b1
   } win_kind_e;
endpackage

// File: rtl/dwf_window.sv
`timescale 1ns/1ps
module dwf_window
   import bwf_pkg::*;
#(
   parameter int W         = 8,
   parameter bit STRIDE_EN = 1'b1
) (
   input  logic [W-1:0] coord,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] stride,
   input  logic [W:0]   span,      // 0 selects the natural span 2^W
   input  logic         wrap_en,
   output logic         hit
);
   localparam logic [W:0] FULL_SPAN = {1'b1, {W{1'b0}}};

   win_kind_e  kind;
   logic       in_rng;
   logic       on_grid;
   logic [W:0] span_eff;
   logic [W:0] off;

   always_comb begin
      kind     = (lo <= hi) ? WIN_LINEAR : WIN_WRAPPED;
      span_eff = (span == '0) ? FULL_SPAN : span;
      if (kind == WIN_LINEAR)
         in_rng = (coord >= lo) && (coord <= hi);
      else
         in_rng = wrap_en && ((coord >= lo) || (coord <= hi));
      if (coord >= lo)
         off = {1'b0, coord} - {1'b0, lo};
      else
         off = {1'b0, coord} + span_eff - {1'b0, lo};
   end

   generate
      if (STRIDE_EN) begin : g_stride
         always_comb begin
            if (stride <= W'(1))
               on_grid = 1'b1;
            else
               on_grid = ((off % {1'b0, stride}) == '0);
         end
      end else begin : g_no_stride
         logic unused_stride;
         assign unused_stride = ^{stride, off};
         assign on_grid = 1'b1;
      end
   endgenerate

   assign hit = in_rng && on_grid;

   // R4: without wrap enabled, a hit always lies inside an ordinary bound pair
   always_comb begin
      if (hit && !wrap_en)
         p_plain_window_r4: assert (coord >= lo && coord <= hi)
            else $error("window hit outside bounds with wrap disabled");
   end
endmodule

// File: rtl/dwf_fifo.sv
`timescale 1ns/1ps
module dwf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] in_word,
   input  logic         pop,
   output logic [W-1:0] out_word,
   output logic         full,
   output logic         empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [AW:0]   fill;
   logic          do_push;
   logic          do_pop;

   assign full    = (fill == (AW+1)'(DEPTH));
   assign empty   = (fill == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign out_word = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= in_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   // R7: the writer never offers a word while the queue is full
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R7: occupancy never exceeds the configured depth
   p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= (AW+1)'(DEPTH));

   // R6: a queue that stays empty across a cycle without a push remains empty
   p_empty_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !push) |=> empty);
endmodule

// File: rtl/bcast_window_filter.sv
`timescale 1ns/1ps
module bcast_window_filter #(
   parameter int ROW_W      = 8,
   parameter int COL_W      = 8,
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 4,
   parameter int CNT_W      = 16,
   parameter bit STRIDE_EN  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   pass_start,
   input  logic                   cfg_mod_en,
   input  logic [ROW_W-1:0]       cfg_row_lo,
   input  logic [ROW_W-1:0]       cfg_row_hi,
   input  logic [ROW_W-1:0]       cfg_row_stride,
   input  logic [COL_W-1:0]       cfg_col_lo,
   input  logic [COL_W-1:0]       cfg_col_hi,
   input  logic [COL_W-1:0]       cfg_col_stride,
   input  logic [COL_W:0]         cfg_vec_len,
   input  logic                   bc_valid,
   input  logic [ROW_W+COL_W-1:0] bc_addr,
   input  logic [DATA_W-1:0]      bc_data,
   output logic                   bc_ready,
   output logic                   pe_valid,
   output logic [ROW_W+COL_W-1:0] pe_addr,
   output logic [DATA_W-1:0]      pe_data,
   input  logic                   pe_ready,
   output logic [CNT_W-1:0]       match_count
);
   localparam int ADDR_W = ROW_W + COL_W;
   localparam int WORD_W = ADDR_W + DATA_W;

   // elaboration-time parameter checks
   generate
      if (ROW_W < 1 || COL_W < 1) begin : g_bad_coord
         $error("coordinate widths must be at least one bit");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two of at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least one bit");
      end
   endgenerate

   logic [ROW_W-1:0]  row_coord;
   logic [COL_W-1:0]  col_raw;
   logic [COL_W:0]    col_wide;
   logic [COL_W-1:0]  col_coord;
   logic [COL_W:0]    col_span;
   logic              reduce_col;
   logic              row_hit;
   logic              col_hit;
   logic              accept;
   logic              capture;
   logic              q_full;
   logic              q_empty;
   logic [WORD_W-1:0] q_head;

   assign row_coord  = bc_addr[ADDR_W-1:COL_W];
   assign col_raw    = bc_addr[COL_W-1:0];
   assign reduce_col = cfg_mod_en && (cfg_vec_len != '0);

   always_comb begin
      if (reduce_col) begin
         col_wide = {1'b0, col_raw} % cfg_vec_len;
         col_span = cfg_vec_len;
      end else begin
         col_wide = {1'b0, col_raw};
         col_span = '0;
      end
      col_coord = COL_W'(col_wide);
   end

   dwf_window #(.W(ROW_W), .STRIDE_EN(STRIDE_EN)) u_row_win (
      .coord   (row_coord),
      .lo      (cfg_row_lo),
      .hi      (cfg_row_hi),
      .stride  (cfg_row_stride),
      .span    ('0),
      .wrap_en (cfg_mod_en),
      .hit     (row_hit)
   );

   dwf_window #(.W(COL_W), .STRIDE_EN(STRIDE_EN)) u_col_win (
      .coord   (col_coord),
      .lo      (cfg_col_lo),
      .hi      (cfg_col_hi),
      .stride  (cfg_col_stride),
      .span    (col_span),
      .wrap_en (cfg_mod_en),
      .hit     (col_hit)
   );

   assign bc_ready = !q_full;
   assign accept   = bc_valid && bc_ready;
   assign capture  = accept && row_hit && col_hit;

   dwf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (capture),
      .in_word  ({bc_addr, bc_data}),
      .pop      (pe_ready),
      .out_word (q_head),
      .full     (q_full),
      .empty    (q_empty)
   );

   assign pe_valid = !q_empty;
   assign pe_addr  = q_head[WORD_W-1:DATA_W];
   assign pe_data  = q_head[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         match_count <= '0;
      else if (pass_start)
         match_count <= capture ? CNT_W'(1) : '0;
      else if (capture)
         match_count <= match_count + 1'b1;
   end

   // R8: a pass start leaves at most one capture on the counter
   p_pass_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pass_start |=> (match_count <= CNT_W'(1)));

   // R8: outside a pass start the counter moves by zero or one
   p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pass_start |=> (match_count == $past(match_count)
                       || match_count == CNT_W'($past(match_count) + 1'b1)));

   // R7: a stalled beat does not change the count
   p_stall_no_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && !bc_ready && !pass_start) |=> $stable(match_count));

   // R6: output becomes valid only after a broadcast beat was taken
   p_out_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pe_valid) |-> $past(bc_valid && bc_ready));
endmodule

// File: tb/bcast_window_filter_tb_top.sv
`timescale 1ns/1ps
module bcast_window_filter_tb_top;
   localparam int RW = 4;
   localparam int CW = 4;
   localparam int DW = 8;
   localparam int NV = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pass_start = 1'b0;
   logic          cfg_mod_en = 1'b0;
   logic [RW-1:0] cfg_row_lo = '0, cfg_row_hi = '0, cfg_row_stride = '0;
   logic [CW-1:0] cfg_col_lo = '0, cfg_col_hi = '0, cfg_col_stride = '0;
   logic [CW:0]   cfg_vec_len = '0;
   logic          bc_valid = 1'b0;
   logic [7:0]    bc_addr = '0;
   logic [DW-1:0] bc_data = '0;
   logic          bc_ready;
   logic          pe_valid;
   logic [7:0]    pe_addr;
   logic [DW-1:0] pe_data;
   logic          pe_ready = 1'b0;
   logic [7:0]    match_count;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   bcast_window_filter #(
      .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .FIFO_DEPTH(4), .CNT_W(8), .STRIDE_EN(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pass_start(pass_start), .cfg_mod_en(cfg_mod_en),
      .cfg_row_lo(cfg_row_lo), .cfg_row_hi(cfg_row_hi), .cfg_row_stride(cfg_row_stride),
      .cfg_col_lo(cfg_col_lo), .cfg_col_hi(cfg_col_hi), .cfg_col_stride(cfg_col_stride),
      .cfg_vec_len(cfg_vec_len), .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_data(bc_data),
      .bc_ready(bc_ready), .pe_valid(pe_valid), .pe_addr(pe_addr), .pe_data(pe_data),
      .pe_ready(pe_ready), .match_count(match_count)
   );

   // layout: mod | rlo rhi rstep | clo chi cstep | vlen(5) | addr(8) | expected hit
   localparam logic [38:0] VECS [NV] = '{
      {1'b0, 4'd2,  4'd5,  4'd0, 4'd0,  4'd15, 4'd0, 5'd0,  8'h3A, 1'b1},
      {1'b0, 4'd2,  4'd5,  4'd0, 4'd0,  4'd15, 4'd0, 5'd0,  8'h6A, 1'b0},
      {1'b0, 4'd2,  4'd5,  4'd0, 4'd0,  4'd15, 4'd0, 5'd0,  8'h5F, 1'b1},
      {1'b0, 4'd0,  4'd15, 4'd0, 4'd4,  4'd9,  4'd0, 5'd0,  8'h09, 1'b1},
      {1'b0, 4'd0,  4'd15, 4'd0, 4'd4,  4'd9,  4'd0, 5'd0,  8'h0A, 1'b0},
      {1'b0, 4'd0,  4'd15, 4'd0, 4'd4,  4'd9,  4'd3, 5'd0,  8'h07, 1'b1},
      {1'b0, 4'd0,  4'd15, 4'd0, 4'd4,  4'd9,  4'd3, 5'd0,  8'h08, 1'b0},
      {1'b0, 4'd1,  4'd15, 4'd2, 4'd0,  4'd15, 4'd0, 5'd0,  8'h30, 1'b1},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd12, 4'd2,  4'd0, 5'd0,  8'h01, 1'b1},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd12, 4'd2,  4'd0, 5'd0,  8'h07, 1'b0},
      {1'b0, 4'd0,  4'd15, 4'd0, 4'd12, 4'd2,  4'd0, 5'd0,  8'h0D, 1'b0},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd0,  4'd2,  4'd0, 5'd10, 8'h0B, 1'b1},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd0,  4'd2,  4'd0, 5'd10, 8'h0F, 1'b0},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd8,  4'd3,  4'd3, 5'd10, 8'h01, 1'b1},
      {1'b1, 4'd0,  4'd15, 4'd0, 4'd8,  4'd3,  4'd3, 5'd10, 8'h02, 1'b0},
      {1'b1, 4'd14, 4'd1,  4'd0, 4'd0,  4'd15, 4'd0, 5'd0,  8'hF5, 1'b1}
   };

   function automatic string vtag(int i);
      if (i < 3)       return "R1";
      else if (i < 5)  return "R2";
      else if (i < 8)  return "R3";
      else if (i < 11) return "R4";
      else if (i < 13) return "R5";
      else if (i < 15) return "R3";
      else             return "R4";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   task automatic send(input logic [7:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bc_addr  = a;
      bc_data  = d;
      bc_valid = 1'b1;
      while (!bc_ready) @(negedge clk);
      @(negedge clk);
      bc_valid = 1'b0;
   endtask

   task automatic open_all();
      cfg_mod_en = 1'b0;
      cfg_row_lo = 4'd0; cfg_row_hi = 4'd15; cfg_row_stride = 4'd0;
      cfg_col_lo = 4'd0; cfg_col_hi = 4'd15; cfg_col_stride = 4'd0;
      cfg_vec_len = 5'd0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: state after reset
      check("R9 pe_valid", 32'(pe_valid), 32'd0);
      check("R9 bc_ready", 32'(bc_ready), 32'd1);
      check("R9 match_count", 32'(match_count), 32'd0);

      // table of window cases, one beat per pass
      for (int i = 0; i < NV; i++) begin
         logic [38:0] v;
         v = VECS[i];
         @(negedge clk);
         cfg_mod_en     = v[38];
         cfg_row_lo     = v[37:34];
         cfg_row_hi     = v[33:30];
         cfg_row_stride = v[29:26];
         cfg_col_lo     = v[25:22];
         cfg_col_hi     = v[21:18];
         cfg_col_stride = v[17:14];
         cfg_vec_len    = v[13:9];
         bc_addr        = v[8:1];
         bc_data        = 8'(8'h40 + i);
         bc_valid       = 1'b1;
         pass_start     = 1'b1;
         @(negedge clk);
         bc_valid   = 1'b0;
         pass_start = 1'b0;
         check(vtag(i), 32'(pe_valid), 32'(v[0]));
         // R8: capture in the pass-start cycle counts as one
         check("R8 count with pass start", 32'(match_count), 32'(v[0]));
         if (v[0]) begin
            check("R6 data", 32'(pe_data), 32'(8'(8'h40 + i)));
            check("R6 addr", 32'(pe_addr), 32'(v[8:1]));
         end
         pe_ready = 1'b1;
         @(negedge clk);
         pe_ready = 1'b0;
      end

      // R10: non-matching beats leave outputs and counter alone
      @(negedge clk);
      cfg_mod_en = 1'b0;
      cfg_row_lo = 4'd2; cfg_row_hi = 4'd5; cfg_row_stride = 4'd0;
      cfg_col_lo = 4'd0; cfg_col_hi = 4'd15; cfg_col_stride = 4'd0;
      pass_start = 1'b1;
      @(negedge clk);
      pass_start = 1'b0;
      send(8'h70, 8'hE1);
      send(8'h1F, 8'hE2);
      send(8'h00, 8'hE3);
      check("R10 pe_valid", 32'(pe_valid), 32'd0);
      check("R10 match_count", 32'(match_count), 32'd0);
      check("R10 bc_ready", 32'(bc_ready), 32'd1);

      // R7: fill the queue, hold a waiting beat, drain in order
      open_all();
      pass_start = 1'b1;
      @(negedge clk);
      pass_start = 1'b0;
      for (int k = 0; k < 4; k++) send(8'(8'h20 + k), 8'(8'h10 + k));
      check("R7 ready low when full", 32'(bc_ready), 32'd0);
      check("R8 count after four", 32'(match_count), 32'd4);
      check("R6 head is oldest", 32'(pe_data), 32'h10);
      bc_addr  = 8'h55;
      bc_data  = 8'h99;
      bc_valid = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 stalled beat not counted", 32'(match_count), 32'd4);
      check("R7 head unchanged", 32'(pe_data), 32'h10);
      bc_valid = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check("R6 order valid", 32'(pe_valid), 32'd1);
         check("R6 order data", 32'(pe_data), 32'(8'(8'h10 + k)));
         pe_ready = 1'b1;
         @(negedge clk);
      end
      pe_ready = 1'b0;
      check("R6 empty after drain", 32'(pe_valid), 32'd0);
      send(8'h55, 8'h99);
      check("R7 held beat delivered", 32'(pe_data), 32'h99);
      check("R8 count continues", 32'(match_count), 32'd5);

      // R8: pass start without capture clears the counter
      @(negedge clk);
      pass_start = 1'b1;
      @(negedge clk);
      pass_start = 1'b0;
      check("R8 cleared", 32'(match_count), 32'd0);
      check("R8 queue kept", 32'(pe_data), 32'h99);

      summary();
      $finish;
   end
endmodule